// File: doc/BRIEF.md
# Correlator Accumulation Ready and Overrun Flags

This block keeps, for every correlator channel, a flag that tells the processor a fresh set of accumulations is waiting, and a second flag that records when a dump overwrote a set that had not yet been collected. Each dump strobe from a channel sets its ready flag. The processor collects the four accumulators of a channel in any order. Only the read of the quadrature-prompt accumulator retires the ready flag, so software should read that register last.

The overrun flag is sticky. Reading data does not clear it, and neither do further dumps. It clears only on a write to the channel's accumulation-reset strobe, or when the channel is made inactive. An inactive channel holds both flags low and ignores its dumps.

A level-sensitive interrupt is raised while any ready flag is set and the global interrupt enable is high. Software may also poll the two status words instead of using the interrupt.

Top module: `acc_ready_flags`

## Requirements
- R1: After reset, the ready word, the missed word and the interrupt are all zero.
- R2: A dump on an active channel sets that channel's ready bit on the next clock edge.
- R3: A read strobe with selector code 3 (quadrature prompt) clears that channel's ready bit on the next edge, provided there is no dump in the same cycle.
- R4: A read strobe with selector code 0 (in-phase tracking), 1 (quadrature tracking) or 2 (in-phase prompt) leaves the ready bit unchanged.
- R5: A dump on an active channel whose ready bit is set, with no clearing read in the same cycle, sets that channel's missed bit on the next edge.
- R6: When a dump and a clearing read hit one channel in the same cycle, the ready bit stays set and the missed bit is not set.
- R7: A missed bit stays set through reads and further dumps while the channel stays active and no reset write occurs.
- R8: An accumulation-reset write clears the channel's missed bit on the next edge. It wins over a miss in the same cycle and leaves the ready bit alone.
- R9: While a channel's active input is low, its ready and missed bits are zero from the next edge onward, and its dumps are ignored.
- R10: The interrupt is high in exactly those cycles where the enable is high and at least one ready bit is set. It follows the flags with no extra register.
- R11: Each channel's flags depend only on that channel's strobes, plus the shared read selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dump | input | NCH | Per-channel dump strobe |
| rd_stb | input | NCH | Per-channel accumulator read strobe |
| rd_sel | input | 2 | Which accumulator is read (3 = quadrature prompt) |
| acc_rst_wr | input | NCH | Per-channel accumulation-reset write strobe |
| chan_active | input | NCH | Per-channel active level |
| irq_en | input | 1 | Global interrupt enable |
| ready_o | output | NCH | New-data status word |
| missed_o | output | NCH | Missed-data status word |
| irq_o | output | 1 | Level interrupt |

## Verification
Every flag result is due one clock edge after the strobe that causes it. The interrupt is due in the same cycle as the flag or enable that drives it. The bench drives strobes just after a falling edge and keeps them stable over the next rising edge. At that rising edge it advances its own flag model from the same inputs. At the following falling edge it compares the ready word, the missed word and the interrupt against the model. This means every comparison falls exactly one register stage after its cause.

// File: rtl/acc_ready_flags.sv
module acc_ready_flags #(
  parameter int NCH = 12,
  parameter logic [1:0] CLR_SEL = 2'd3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dump,
  input  logic [NCH-1:0] rd_stb,
  input  logic [1:0]     rd_sel,
  input  logic [NCH-1:0] acc_rst_wr,
  input  logic [NCH-1:0] chan_active,
  input  logic           irq_en,
  output logic [NCH-1:0] ready_o,
  output logic [NCH-1:0] missed_o,
  output logic           irq_o
);

  logic [NCH-1:0] clr_rd;
  logic [NCH-1:0] ready_q, missed_q;

  assign clr_rd = rd_stb & {NCH{rd_sel == CLR_SEL}};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic overrun;
    assign overrun = dump[i] & ready_q[i] & ~clr_rd[i];

    always_ff @(posedge clk) begin
      if (!rst_n || !chan_active[i]) begin
        ready_q[i]  <= 1'b0;
        missed_q[i] <= 1'b0;
      end else begin
        ready_q[i]  <= dump[i] | (ready_q[i] & ~clr_rd[i]);
        missed_q[i] <= ~acc_rst_wr[i] & (missed_q[i] | overrun);
      end
    end
  end

  assign ready_o  = ready_q;
  assign missed_o = missed_q;
  assign irq_o    = irq_en & (|ready_q);

endmodule

// File: rtl/acc_ready_flags_chk.sv
module acc_ready_flags_chk #(
  parameter int NCH = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dump,
  input logic [NCH-1:0] rd_stb,
  input logic [1:0]     rd_sel,
  input logic [NCH-1:0] acc_rst_wr,
  input logic [NCH-1:0] chan_active,
  input logic           irq_en,
  input logic [NCH-1:0] ready_o,
  input logic [NCH-1:0] missed_o,
  input logic           irq_o
);

  logic [NCH-1:0] qp_rd;
  assign qp_rd = rd_stb & {NCH{rd_sel == 2'd3}};

  // R2
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(dump & chan_active) |=> ((ready_o & $past(dump & chan_active)) == $past(dump & chan_active)));

  // R3
  ready_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(qp_rd & ~dump) |=> ((ready_o & $past(qp_rd & ~dump)) == '0));

  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(ready_o & chan_active & ~qp_rd) |=>
      ((ready_o & $past(ready_o & chan_active & ~qp_rd)) == $past(ready_o & chan_active & ~qp_rd)));

  // R5
  miss_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(dump & ready_o & ~qp_rd & chan_active & ~acc_rst_wr) |=>
      ((missed_o & $past(dump & ready_o & ~qp_rd & chan_active & ~acc_rst_wr))
        == $past(dump & ready_o & ~qp_rd & chan_active & ~acc_rst_wr)));

  // R7
  miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(missed_o & chan_active & ~acc_rst_wr) |=>
      ((missed_o & $past(missed_o & chan_active & ~acc_rst_wr)) == $past(missed_o & chan_active & ~acc_rst_wr)));

  // R9
  inactive_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(~chan_active) |=> (((ready_o | missed_o) & $past(~chan_active)) == '0));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_en);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o == '0) |-> !irq_o);

endmodule

bind acc_ready_flags acc_ready_flags_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dump(dump), .rd_stb(rd_stb), .rd_sel(rd_sel),
  .acc_rst_wr(acc_rst_wr), .chan_active(chan_active), .irq_en(irq_en),
  .ready_o(ready_o), .missed_o(missed_o), .irq_o(irq_o)
);

// File: tb/test_acc_ready_flags.sv
module test_acc_ready_flags;
  localparam int NCH = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] dump = '0, rd_stb = '0, acc_rst_wr = '0, chan_active = '0;
  logic [1:0] rd_sel = 2'd0;
  logic irq_en = 1'b0;
  logic [NCH-1:0] ready_o, missed_o;
  logic irq_o;

  logic [NCH-1:0] m_ready = '0, m_missed = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  acc_ready_flags #(.NCH(NCH)) i_acc_ready_flags (
    .clk(clk), .rst_n(rst_n), .dump(dump), .rd_stb(rd_stb), .rd_sel(rd_sel),
    .acc_rst_wr(acc_rst_wr), .chan_active(chan_active), .irq_en(irq_en),
    .ready_o(ready_o), .missed_o(missed_o), .irq_o(irq_o)
  );

  function automatic logic [NCH-1:0] nxt_missed(logic [NCH-1:0] r, logic [NCH-1:0] m);
    logic [NCH-1:0] clr = rd_stb & {NCH{rd_sel == 2'd3}};
    return chan_active & ~acc_rst_wr & (m | (dump & r & ~clr));
  endfunction

  function automatic logic [NCH-1:0] nxt_ready(logic [NCH-1:0] r);
    logic [NCH-1:0] clr = rd_stb & {NCH{rd_sel == 2'd3}};
    return chan_active & (dump | (r & ~clr));
  endfunction

  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      m_ready = '0; m_missed = '0;
    end else begin
      m_missed = nxt_missed(m_ready, m_missed);
      m_ready  = nxt_ready(m_ready);
    end
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cmp(string tag);
    chk(tag, ready_o, m_ready, "ready");
    chk(tag, missed_o, m_missed, "missed");
    chk(tag, NCH'(irq_o), NCH'(irq_en & (|m_ready)), "irq");
  endtask

  task automatic idle();
    dump = '0; rd_stb = '0; acc_rst_wr = '0; rd_sel = 2'd0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20250611));
    @(negedge clk);
    tick(); tick();
    chk("R1", ready_o, '0, "ready");
    chk("R1", missed_o, '0, "missed");
    chk("R1", NCH'(irq_o), '0, "irq");
    rst_n = 1'b1; chan_active = '1; irq_en = 1'b1;
    tick(); cmp("R1");

    dump = 12'h001; tick(); idle(); cmp("R2");
    chk("R2", ready_o, 12'h001, "ready direct");
    for (int s = 0; s < 3; s++) begin
      rd_stb = 12'h001; rd_sel = 2'(s); tick(); idle(); cmp("R4");
      chk("R4", ready_o, 12'h001, "ready direct");
    end
    rd_stb = 12'h001; rd_sel = 2'd3; tick(); idle(); cmp("R3");
    chk("R3", ready_o, 12'h000, "ready direct");

    dump = 12'h002; tick(); tick(); idle(); cmp("R5");
    chk("R5", missed_o, 12'h002, "missed direct");

    dump = 12'h004; tick();
    rd_stb = 12'h004; rd_sel = 2'd3; tick(); idle(); cmp("R6");
    chk("R6", ready_o & 12'h004, 12'h004, "ready direct");
    chk("R6", missed_o & 12'h004, 12'h000, "missed direct");

    rd_stb = 12'h002; rd_sel = 2'd3; tick(); idle();
    dump = 12'h002; tick(); idle(); cmp("R7");
    chk("R7", missed_o & 12'h002, 12'h002, "missed direct");

    dump = 12'h002; acc_rst_wr = 12'h002; tick(); idle(); cmp("R8");
    chk("R8", missed_o & 12'h002, 12'h000, "missed direct");
    chk("R8", ready_o & 12'h002, 12'h002, "ready direct");

    dump = 12'h008; tick(); dump = 12'h008; tick(); idle();
    chan_active = 12'hFF7; dump = 12'h008; tick(); idle(); cmp("R9");
    chk("R9", (ready_o | missed_o) & 12'h008, 12'h000, "flags direct");
    chan_active = '1;

    irq_en = 1'b0; #1; cmp("R10");
    chk("R10", NCH'(irq_o), '0, "irq masked");
    irq_en = 1'b1; #1; cmp("R10");

    for (int n = 0; n < 3000; n++) begin
      dump = NCH'($urandom) & NCH'($urandom);
      rd_stb = NCH'($urandom) & NCH'($urandom);
      rd_sel = 2'($urandom);
      acc_rst_wr = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      chan_active = ~(NCH'($urandom) & NCH'($urandom) & NCH'($urandom) & NCH'($urandom));
      irq_en = ($urandom % 8) != 0;
      tick(); cmp("R11");
    end
    idle();
    finish_up();
  end
endmodule